// File: doc/BRIEF.md
# Timed Register Pattern Player

This block drives one register of a parallel-port style interface from a byte array held in an attached memory. It runs three command modes. In the paced mode the array holds pairs of bytes: a value to write to the selected register, then a wait in microseconds. The block writes the value, waits, and moves on to the next pair. This produces exact, repeatable waveforms on the port pins without software in the loop.

The two burst modes step an auto-incrementing pointer. The first sends a run of bytes to one register on consecutive clocks. The second samples one register on consecutive clocks, masks each sample and stores it in memory.

A command is a single-cycle `start` that carries the mode, the register select, a count, a base address and a mask. The count is in pairs for the paced mode and in bytes for the burst modes. `start` is accepted only while the block is idle. The block reports completion with a one-cycle `done`. Memory reads and register reads are combinational: the data belongs to the address or read strobe of the same cycle. The parameter `CLK_PER_US` gives the number of clocks in one microsecond.

Top module: `tpp_top`

## Requirements
- R1: After reset, `done`, `regWrEn`, `regRdEn` and `memWrEn` are all low and no command is in progress.
- R2: Paced mode (`cmdMode` = 0) with count N issues N register writes. Write i carries `cmdReg` on `regSel` and carries the memory byte at `cmdBase + 2i` on `regWrData`. The byte at `cmdBase + 2i + 1` is the wait for that step.
- R3: In paced mode, write i+1 comes exactly 2 + d_i * `CLK_PER_US` clocks after write i, where d_i is the wait byte of step i. A wait byte of 0 therefore gives a spacing of 2 clocks, and the largest wait, 255, gives 2 + 255 * `CLK_PER_US`. The first write comes in the first cycle after `start` is taken.
- R4: `done` is high for exactly one cycle. In paced mode that cycle lies 2 + d_last * `CLK_PER_US` clocks after the last write.
- R5: A count of 0, in any mode, raises `done` in the cycle after `start` is taken and produces no register or memory strobe.
- R6: Burst-write mode (`cmdMode` = 1) with count N writes the bytes at `cmdBase + i` to register `cmdReg` on N consecutive clocks, starting in the first cycle after `start`. `done` follows in the next cycle.
- R7: Burst-read mode (`cmdMode` = 2) with count N raises `regRdEn` on N consecutive clocks, starting in the first cycle after `start`. Each sample of `regRdData` ANDed with `cmdMask` is written to `cmdBase + i`. `done` follows the last sample.
- R8: A `start` that arrives while a command is in progress is ignored, including a `start` in the `done` cycle. The running command's writes and its single `done` are unchanged.
- R9: The pointer wraps modulo 2^`ADDR_W`, so a burst that crosses the top of memory continues at address 0.
- R10: Mode value 3 is reserved. It completes like a count of 0, with a single `done` and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| cmdMode | input | 2 | 0 paced, 1 burst write, 2 burst read, 3 reserved |
| cmdReg | input | REG_W | Register select for the command |
| cmdLen | input | LEN_W | Pair count (paced) or byte count (burst) |
| cmdBase | input | ADDR_W | Start address in memory |
| cmdMask | input | 8 | AND mask for burst-read samples |
| memAddr | output | ADDR_W | Memory address |
| memRdData | input | 8 | Memory read data for memAddr, same cycle |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write data |
| regWrEn | output | 1 | Register write strobe |
| regRdEn | output | 1 | Register read strobe |
| regSel | output | REG_W | Selected register |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data, same cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Paced mode is swept over every count from 0 to 5. The wait bytes mix 0, middling values and 255. This separates an off-by-one in the wait counter, which shifts every later write, from a pointer error, which scrambles the data. Burst writes run both inside memory and across the top address, which exposes a missing wrap. Burst reads take a register value that changes every cycle and use a sparse mask, so a sample taken one cycle off or stored unmasked shows up at once. Extra `start` pulses are sent both in the middle of a paced run and in the `done` cycle, and checked against the same expected write timeline.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  typedef enum logic [1:0] {
    MODE_PACED = 2'd0,
    MODE_BWR   = 2'd1,
    MODE_BRD   = 2'd2,
    MODE_RSV   = 2'd3
  } modeT;

  typedef struct packed {
    logic load;
    logic ptrInc;
    logic cntDec;
    logic dlyLoad;
    logic dlyDec;
  } strobeT;
endpackage

// File: rtl/tpp_datapath.sv
module tpp_datapath
  import tpp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 8,
  parameter int REG_W      = 3,
  parameter int CLK_PER_US = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [7:0]        cmdMask,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic [REG_W-1:0]  regSel,
  output logic [7:0]        regWrData,
  output logic              cntIsOne,
  output logic              dlyIsOne,
  output logic              dlyByteZero
);
  localparam int DLY_W = 8 + $clog2(CLK_PER_US + 1);
  localparam logic [DLY_W-1:0] TICKS = DLY_W'(CLK_PER_US);

  logic [ADDR_W-1:0] ptrQ;
  logic [LEN_W-1:0]  cntQ;
  logic [DLY_W-1:0]  dlyQ;
  logic [REG_W-1:0]  selQ;
  logic [7:0]        maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      cntQ  <= '0;
      selQ  <= '0;
      maskQ <= '0;
    end else if (stb.load) begin
      ptrQ  <= cmdBase;
      cntQ  <= cmdLen;
      selQ  <= cmdReg;
      maskQ <= cmdMask;
    end else begin
      if (stb.ptrInc) ptrQ <= ptrQ + 1'b1;
      if (stb.cntDec) cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dlyQ <= '0;
    else if (stb.dlyLoad) dlyQ <= DLY_W'(memRdData) * TICKS;
    else if (stb.dlyDec)  dlyQ <= dlyQ - 1'b1;
  end

  assign memAddr     = ptrQ;
  assign memWrData   = regRdData & maskQ;
  assign regSel      = selQ;
  assign regWrData   = memRdData;
  assign cntIsOne    = (cntQ == LEN_W'(1));
  assign dlyIsOne    = (dlyQ == DLY_W'(1));
  assign dlyByteZero = (memRdData == 8'h00);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(selQ) && $stable(maskQ));
  // R3
  dly_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.dlyDec |-> dlyQ != '0);
  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrInc && !stb.load && ptrQ == '1) |=> ptrQ == '0);
endmodule

// File: rtl/tpp_control.sv
module tpp_control
  import tpp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cmdMode,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             cntIsOne,
  input  logic             dlyIsOne,
  input  logic             dlyByteZero,
  output strobeT           stb,
  output logic             regWrEn,
  output logic             regRdEn,
  output logic             memWrEn,
  output logic             done
);
  typedef enum logic [2:0] {
    S_IDLE, S_PWR, S_PDLY, S_PWAIT, S_BWR, S_BRD, S_DONE
  } stateT;

  stateT state, nextState;
  logic  lastStep;

  assign lastStep = cntIsOne;

  always_comb begin
    nextState = state;
    stb       = '0;
    regWrEn   = 1'b0;
    regRdEn   = 1'b0;
    memWrEn   = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        stb.load = 1'b1;
        if (cmdLen == '0) nextState = S_DONE;
        else begin
          unique case (modeT'(cmdMode))
            MODE_PACED: nextState = S_PWR;
            MODE_BWR:   nextState = S_BWR;
            MODE_BRD:   nextState = S_BRD;
            default:    nextState = S_DONE;
          endcase
        end
      end
      S_PWR: begin
        regWrEn    = 1'b1;
        stb.ptrInc = 1'b1;
        nextState  = S_PDLY;
      end
      S_PDLY: begin
        stb.ptrInc = 1'b1;
        if (dlyByteZero) begin
          stb.cntDec = 1'b1;
          nextState  = lastStep ? S_DONE : S_PWR;
        end else begin
          stb.dlyLoad = 1'b1;
          nextState   = S_PWAIT;
        end
      end
      S_PWAIT: begin
        stb.dlyDec = 1'b1;
        if (dlyIsOne) begin
          stb.cntDec = 1'b1;
          nextState  = lastStep ? S_DONE : S_PWR;
        end
      end
      S_BWR: begin
        regWrEn    = 1'b1;
        stb.ptrInc = 1'b1;
        stb.cntDec = 1'b1;
        if (lastStep) nextState = S_DONE;
      end
      S_BRD: begin
        regRdEn    = 1'b1;
        memWrEn    = 1'b1;
        stb.ptrInc = 1'b1;
        stb.cntDec = 1'b1;
        if (lastStep) nextState = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !regWrEn && !regRdEn && !memWrEn);
endmodule

// File: rtl/tpp_top.sv
module tpp_top
  import tpp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 8,
  parameter int REG_W      = 3,
  parameter int CLK_PER_US = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cmdMode,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [7:0]        cmdMask,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [REG_W-1:0]  regSel,
  output logic [7:0]        regWrData,
  input  logic [7:0]        regRdData,
  output logic              done
);
  strobeT stb;
  logic   cntIsOne, dlyIsOne, dlyByteZero;

  tpp_control #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdMode(cmdMode), .cmdLen(cmdLen),
    .cntIsOne(cntIsOne), .dlyIsOne(dlyIsOne), .dlyByteZero(dlyByteZero),
    .stb(stb), .regWrEn(regWrEn), .regRdEn(regRdEn), .memWrEn(memWrEn),
    .done(done)
  );

  tpp_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W), .CLK_PER_US(CLK_PER_US)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdReg(cmdReg), .cmdLen(cmdLen),
    .cmdBase(cmdBase), .cmdMask(cmdMask), .memRdData(memRdData),
    .regRdData(regRdData), .memAddr(memAddr), .memWrData(memWrData),
    .regSel(regSel), .regWrData(regWrData), .cntIsOne(cntIsOne),
    .dlyIsOne(dlyIsOne), .dlyByteZero(dlyByteZero)
  );

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && $past(regWrEn)) |-> memAddr == ADDR_W'($past(memAddr) + 1'b1));
  // R7
  read_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> memAddr == ADDR_W'($past(memAddr) + 1'b1));
endmodule

// File: tb/tpp_top_tb_top.sv
module tpp_top_tb_top;
  localparam int K = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] cmdMode = 2'd0;
  logic [2:0] cmdReg = 3'd0;
  logic [7:0] cmdLen = 8'd0;
  logic [7:0] cmdBase = 8'd0;
  logic [7:0] cmdMask = 8'hFF;
  logic [7:0] memAddr, memWrData, regWrData, regRdData, memRdData;
  logic [2:0] regSel;
  logic       memWrEn, regWrEn, regRdEn, done;

  logic [7:0] mem [256];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int nWr, nDone, doneCyc, sCyc;
  int wrCyc [64];
  logic [7:0] wrDat [64];
  logic [2:0] wrSel [64];

  always #5 clk = ~clk;

  tpp_top #(.ADDR_W(8), .LEN_W(8), .REG_W(3), .CLK_PER_US(K)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdMode(cmdMode), .cmdReg(cmdReg),
    .cmdLen(cmdLen), .cmdBase(cmdBase), .cmdMask(cmdMask), .memAddr(memAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .done(done)
  );

  assign memRdData = mem[memAddr];
  assign regRdData = 8'(cyc * 7 + 3);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memWrEn) mem[memAddr] <= memWrData;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (regWrEn && nWr < 64) begin
      wrCyc[nWr] = cyc; wrDat[nWr] = regWrData; wrSel[nWr] = regSel;
      nWr = nWr + 1;
    end
    if (done) begin
      nDone = nDone + 1; doneCyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input int len, input int base, input logic [7:0] mask);
    @(negedge clk);
    nWr = 0; nDone = 0;
    cmdMode = m; cmdReg = 3'(len + 2); cmdLen = 8'(len); cmdBase = 8'(base); cmdMask = mask;
    start = 1'b1;
    @(posedge clk); #1 sCyc = cyc;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic finishRun();
    for (int i = 0; i < 4000 && nDone == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkPaced(input int len, input int base, input string tag);
    int t;
    t = sCyc;
    chk(nWr == len, {tag, " R2 write count"}, nWr, len);
    for (int i = 0; i < len && i < nWr; i++) begin
      chk(wrDat[i] == mem[8'(base + 2 * i)], {tag, " R2 data"}, wrDat[i], mem[8'(base + 2 * i)]);
      chk(wrSel[i] == 3'(len + 2), {tag, " R2 select"}, wrSel[i], len + 2);
      chk(wrCyc[i] == t, {tag, " R3 write timing"}, wrCyc[i], t);
      t = t + 2 + K * int'(mem[8'(base + 2 * i + 1)]);
    end
    chk(nDone == 1, {tag, " R4 single done"}, nDone, 1);
    chk(doneCyc == t, {tag, " R4 done timing"}, doneCyc, t);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a * 29 + 11);
    nWr = 0; nDone = 0; doneCyc = 0;
    repeat (3) @(negedge clk);
    chk(!done && !regWrEn && !regRdEn && !memWrEn, "R1 outputs in reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !regWrEn && !regRdEn && !memWrEn, "R1 idle after reset",
        int'({done, regWrEn, regRdEn, memWrEn}), 0);

    // R2 R3 R4 R5: paced sweep over count 0..5
    for (int len = 0; len <= 5; len++) begin
      int base = len * 40;
      for (int i = 0; i < len; i++) begin
        int d = ((i + len) % 3 == 0) ? 0 : ((i * 53 + len * 17) % 256);
        if (len == 5 && i == 4) d = 255;
        mem[8'(base + 2 * i + 1)] = 8'(d);
      end
      issue(2'd0, len, base, 8'hFF);
      finishRun();
      checkPaced(len, base, len == 0 ? "R5 paced len0" : "paced");
    end

    // R6: burst write inside memory
    issue(2'd1, 6, 100, 8'hFF);
    finishRun();
    chk(nWr == 6, "R6 burst count", nWr, 6);
    for (int i = 0; i < 6 && i < nWr; i++) begin
      chk(wrDat[i] == mem[100 + i], "R6 burst data", wrDat[i], mem[100 + i]);
      chk(wrCyc[i] == sCyc + i, "R6 burst timing", wrCyc[i], sCyc + i);
    end
    chk(nDone == 1 && doneCyc == sCyc + 6, "R6 burst done", doneCyc, sCyc + 6);

    // R9: burst write across the top of memory
    issue(2'd1, 8, 252, 8'hFF);
    finishRun();
    chk(nWr == 8, "R9 wrap count", nWr, 8);
    for (int i = 0; i < 8 && i < nWr; i++)
      chk(wrDat[i] == mem[8'(252 + i)], "R9 wrap data", wrDat[i], mem[8'(252 + i)]);

    // R7: masked burst read
    issue(2'd2, 6, 200, 8'h3C);
    finishRun();
    chk(nWr == 0, "R7 no register writes", nWr, 0);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] e;
      e = 8'((sCyc + i) * 7 + 3) & 8'h3C;
      chk(mem[200 + i] == e, "R7 stored sample", mem[200 + i], e);
    end
    chk(mem[206] == 8'(206 * 29 + 11), "R7 no extra store", mem[206], 8'(206 * 29 + 11));
    chk(nDone == 1 && doneCyc == sCyc + 6, "R7 done timing", doneCyc, sCyc + 6);

    // R5: burst modes with count 0
    issue(2'd2, 0, 210, 8'hFF);
    finishRun();
    chk(mem[210] == 8'(210 * 29 + 11) && nDone == 1 && doneCyc == sCyc, "R5 burst len0",
        doneCyc, sCyc);

    // R10: reserved mode
    issue(2'd3, 4, 20, 8'hFF);
    finishRun();
    chk(nWr == 0 && nDone == 1 && doneCyc == sCyc, "R10 reserved mode", nWr, 0);

    // R8: start while a paced run is busy
    mem[61] = 8'd5; mem[63] = 8'd0; mem[65] = 8'd2;
    issue(2'd0, 3, 60, 8'hFF);
    repeat (4) @(negedge clk);
    cmdMode = 2'd1; cmdLen = 8'd9; cmdBase = 8'd0; cmdReg = 3'd7; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0; cmdReg = 3'(3 + 2);
    finishRun();
    checkPaced(3, 60, "R8 busy start");

    // R8: start during the done cycle
    @(negedge clk);
    nWr = 0; nDone = 0;
    cmdMode = 2'd0; cmdLen = 8'd0; start = 1'b1;
    @(negedge clk);
    cmdMode = 2'd1; cmdLen = 8'd2; cmdBase = 8'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(nWr == 0, "R8 start in done cycle writes", nWr, 0);
    chk(nDone == 1, "R8 start in done cycle done", nDone, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule